// File: doc/BRIEF.md
# Two-Wire Register File Target

This block is a two-wire serial bus target in front of sixteen 8-bit registers. It watches the bus clock and data lines through a faster system clock and finds START and STOP conditions. It compares the first byte of each transfer with its fixed 7-bit bus address. On a match, it acknowledges and moves bytes between the bus and a parallel register port. The block pulls the data line low only through an open-drain enable. Outside the block, that enable is tied to a pull-down with a pull-up resistor.

In a write transfer, the first byte after the address loads a 4-bit register pointer. Each later byte is written through the register port at that pointer, and the pointer then advances. In a read transfer, bytes are sent from the pointer onwards, and the pointer again advances after each byte. Write data is masked per register, so bits that are not implemented are always written as zero. The block raises an access flag from an address match until STOP. The surrounding logic uses this flag to hold its counters steady while a transfer is in progress.

Top module: `i2c_regfile_target`

## Requirements
- R1: The address byte is acknowledged only when its upper seven bits equal 51h (A2h selects write, A3h selects read). Any other address is not acknowledged, causes no register write and leaves the data line released until the next START.
- R2: In a write transfer, the first byte after the address is acknowledged, and its low four bits load the register pointer.
- R3: Each later written byte is acknowledged and produces one single-cycle write strobe at the pointer. The strobe data is the byte ANDed with that register's mask: register 1 keeps bits 4:0, register 2 keeps bits 6:0, and all other registers keep all eight bits. After each such byte the pointer advances by one.
- R4: In a read transfer, the register at the pointer is sent MSB first, and the pointer advances after each byte is fetched. When the controller acknowledges a byte, the next byte follows.
- R5: The pointer wraps from 0Fh back to 00h on both reads and writes.
- R6: After the controller does not acknowledge a read byte, the target keeps the data line released until STOP or START, even if clock pulses continue.
- R7: A repeated START begins a new address phase, and the pointer set earlier is kept. A write of the pointer followed by a repeated START and a read address therefore reads from that pointer.
- R8: The access output is low after reset and rises on an address match. It stays high until STOP, including across a repeated START, and a non-matching address does not raise it.
- R9: The open-drain enable changes only while the clock line is low.
- R10: After reset, the data line is released, the access output is low and no write strobe is active.
- R11: A STOP in the middle of a data byte discards that byte, and no register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls the data line low |
| access_o | output | 1 | Transfer in progress; used to hold counters steady |
| reg_addr_o | output | 4 | Register pointer, used for both reads and writes |
| reg_we_o | output | 1 | Single-cycle register write strobe |
| reg_wdata_o | output | 8 | Masked write data |
| reg_rdata_i | input | 8 | Read data of the register at reg_addr_o |

## Verification
A pointer that is off by one shows up within the next transfer, in two ways: a readback byte comes from the wrong register, and a wrap test reads the wrong neighbour. A byte engine out of step shows up as a missing or misplaced acknowledge on the very next byte. An open-drain enable that moves while the clock is high is caught on the cycle it moves, because the bench compares the enable on every clock. Aborted or foreign transfers are checked through the count of write strobes and the contents of the bench register file.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_WAIT
  } tgt_state_e;
endpackage

// File: rtl/i2c_rf_sync.sv
module i2c_rf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_hi_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sr, sda_sr;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[STAGES-2:0], sda_i};
      scl_d  <= scl_sr[STAGES-1];
      sda_d  <= sda_sr[STAGES-1];
    end
  end

  assign scl_hi_o   = scl_sr[STAGES-1];
  assign sda_o      = sda_sr[STAGES-1];
  assign scl_rise_o = scl_hi_o & ~scl_d;
  assign scl_fall_o = ~scl_hi_o & scl_d;
  // SDA edge while SCL is steadily high
  assign start_o    = scl_hi_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_hi_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/i2c_rf_mask.sv
module i2c_rf_mask #(
  parameter int NUM_REGS = 16,
  parameter int DW = 8,
  parameter logic [NUM_REGS*DW-1:0] WMASK = '1,
  localparam int AW = $clog2(NUM_REGS)
) (
  input  logic [AW-1:0] addr_i,
  output logic [DW-1:0] mask_o
);
  logic [DW-1:0] mask_tbl [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_tbl
    assign mask_tbl[g] = WMASK[g*DW +: DW];
  end

  assign mask_o = mask_tbl[addr_i];
endmodule

// File: rtl/i2c_rf_engine.sv
module i2c_rf_engine
  import i2c_rf_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DW = 8,
  parameter logic [6:0] DEV_ADDR = 7'h51,
  localparam int AW = $clog2(NUM_REGS),
  localparam int CW = $clog2(DW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_hi_i,
  input  logic          sda_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [DW-1:0] mask_i,
  input  logic [DW-1:0] rdata_i,
  output logic          sda_oe_o,
  output logic          access_o,
  output logic [AW-1:0] ptr_o,
  output logic          we_o,
  output logic [DW-1:0] wdata_o
);
  tgt_state_e    state;
  logic [CW-1:0] bit_cnt;
  logic [DW-1:0] shreg;
  logic          rd_dir, mack;

  localparam logic [CW-1:0] FULL = CW'(DW);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      ptr_o    <= '0;
      sda_oe_o <= 1'b0;
      access_o <= 1'b0;
      we_o     <= 1'b0;
      wdata_o  <= '0;
      rd_dir   <= 1'b0;
      mack     <= 1'b0;
    end else begin
      we_o <= 1'b0;
      if (stop_i) begin
        state    <= ST_IDLE;
        sda_oe_o <= 1'b0;
        access_o <= 1'b0;
      end else if (start_i) begin
        state    <= ST_ADDR;
        sda_oe_o <= 1'b0;
        bit_cnt  <= '0;
      end else begin
        case (state)
          ST_ADDR, ST_PTR, ST_WDATA: begin
            if (scl_rise_i) begin
              shreg   <= {shreg[DW-2:0], sda_i};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall_i && bit_cnt == FULL) begin
              bit_cnt <= '0;
              if (state == ST_ADDR) begin
                if (shreg[DW-1:1] == DEV_ADDR) begin
                  access_o <= 1'b1;
                  rd_dir   <= shreg[0];
                  sda_oe_o <= 1'b1;
                  state    <= ST_ADDR_ACK;
                end else begin
                  state <= ST_WAIT;
                end
              end else if (state == ST_PTR) begin
                ptr_o    <= shreg[AW-1:0];
                sda_oe_o <= 1'b1;
                state    <= ST_PTR_ACK;
              end else begin
                we_o     <= 1'b1;
                wdata_o  <= shreg & mask_i;
                sda_oe_o <= 1'b1;
                state    <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall_i) begin
              bit_cnt <= '0;
              if (rd_dir) begin
                shreg    <= rdata_i;
                sda_oe_o <= ~rdata_i[DW-1];
                ptr_o    <= ptr_o + 1'b1;
                state    <= ST_RDATA;
              end else begin
                sda_oe_o <= 1'b0;
                state    <= ST_PTR;
              end
            end
          end
          ST_PTR_ACK: begin
            if (scl_fall_i) begin
              sda_oe_o <= 1'b0;
              state    <= ST_WDATA;
            end
          end
          ST_WDATA_ACK: begin
            if (we_o) ptr_o <= ptr_o + 1'b1;
            if (scl_fall_i) begin
              sda_oe_o <= 1'b0;
              state    <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_rise_i) begin
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall_i) begin
              if (bit_cnt == FULL) begin
                sda_oe_o <= 1'b0;
                state    <= ST_RACK;
              end else begin
                sda_oe_o <= ~shreg[DW-2];
                shreg    <= {shreg[DW-2:0], 1'b0};
              end
            end
          end
          ST_RACK: begin
            if (scl_rise_i) begin
              mack <= ~sda_i;
            end else if (scl_fall_i) begin
              bit_cnt <= '0;
              if (mack) begin
                shreg    <= rdata_i;
                sda_oe_o <= ~rdata_i[DW-1];
                ptr_o    <= ptr_o + 1'b1;
                state    <= ST_RDATA;
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R9
  oe_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_hi_i && $past(scl_hi_i)) |-> $stable(sda_oe_o));
  // R8
  acc_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(access_o) |-> $past(state) == ST_ADDR);
  // R8
  acc_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !access_o);
  // R3
  we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> !we_o);
  // R6
  wait_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_WAIT && $past(state) == ST_WAIT) |-> !sda_oe_o);
  // R3
  we_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> (wdata_o & ~mask_i) == '0);
endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target #(
  parameter int NUM_REGS = 16,
  parameter int DW = 8,
  parameter logic [6:0] DEV_ADDR = 7'h51,
  parameter int SYNC_STAGES = 2,
  parameter logic [NUM_REGS*DW-1:0] WMASK = {{(NUM_REGS-3){8'hFF}}, 8'h7F, 8'h1F, 8'hFF},
  localparam int AW = $clog2(NUM_REGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  output logic          access_o,
  output logic [AW-1:0] reg_addr_o,
  output logic          reg_we_o,
  output logic [DW-1:0] reg_wdata_o,
  input  logic [DW-1:0] reg_rdata_i
);
  logic scl_hi, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [DW-1:0] cur_mask;

  i2c_rf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_hi_o(scl_hi), .sda_o(sda_s), .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall), .start_o(start_det), .stop_o(stop_det)
  );

  i2c_rf_mask #(.NUM_REGS(NUM_REGS), .DW(DW), .WMASK(WMASK)) u_mask (
    .addr_i(reg_addr_o), .mask_o(cur_mask)
  );

  i2c_rf_engine #(.NUM_REGS(NUM_REGS), .DW(DW), .DEV_ADDR(DEV_ADDR)) u_engine (
    .clk_i, .rst_ni,
    .scl_hi_i(scl_hi), .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det), .mask_i(cur_mask), .rdata_i(reg_rdata_i),
    .sda_oe_o, .access_o, .ptr_o(reg_addr_o), .we_o(reg_we_o), .wdata_o(reg_wdata_o)
  );
endmodule

// File: tb/i2c_regfile_target_tb_top.sv
`timescale 1ns/1ps
module i2c_regfile_target_tb_top;
  localparam int Q = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, access, we;
  logic [3:0] addr;
  logic [7:0] wdata, rdata;
  logic sda_bus;
  logic [7:0] dev_mem [16];
  logic [7:0] exp_mem [16];
  int compared = 0, mismatched = 0, we_cnt = 0, exp_we = 0;
  logic oe_prev = 1'b0, scl_prev = 1'b1;
  logic ack_seen;
  logic [7:0] rd_byte;

  always #4 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;
  assign rdata = dev_mem[addr];

  i2c_regfile_target dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .access_o(access), .reg_addr_o(addr),
    .reg_we_o(we), .reg_wdata_o(wdata), .reg_rdata_i(rdata)
  );

  always @(posedge clk) if (we) begin dev_mem[addr] <= wdata; we_cnt <= we_cnt + 1; end

  // R9 per-clock compare: enable must hold while bench SCL is high
  always @(posedge clk) begin
    #1;
    if (rst_n && scl_prev && scl_m) begin
      compared++;
      if (sda_oe !== oe_prev) begin
        mismatched++;
        $display("FAIL R9: sda_oe moved while SCL high act=%0b exp=%0b", sda_oe, oe_prev);
      end
    end
    oe_prev = sda_oe;
    scl_prev = scl_m;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask
  task automatic bus_rstart();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask
  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask
  task automatic send_bit(input logic b);
    sda_m = b; wq(); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq();
  endtask
  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); ack_seen = ~sda_bus; wq(); scl_m = 1'b0; wq();
  endtask
  task automatic recv_byte(input logic give_ack);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wq(); scl_m = 1'b1; wq(); rd_byte = {rd_byte[6:0], sda_bus}; wq(); scl_m = 1'b0; wq();
    end
    sda_m = ~give_ack; wq(); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(); sda_m = 1'b1;
  endtask

  function automatic logic [7:0] mask_of(input int r);
    return (r == 1) ? 8'h1F : (r == 2) ? 8'h7F : 8'hFF;
  endfunction

  task automatic write_regs(input logic [3:0] p, input logic [7:0] d [], input string req);
    int idx;
    bus_start();
    send_byte(8'hA2); chk(ack_seen, "R1", ack_seen, 1);
    chk(access, "R8", access, 1);
    send_byte({4'h0, p}); chk(ack_seen, "R2", ack_seen, 1);
    idx = p;
    foreach (d[k]) begin
      send_byte(d[k]); chk(ack_seen, req, ack_seen, 1);
      exp_mem[idx] = d[k] & mask_of(idx); exp_we++;
      idx = (idx + 1) % 16;
    end
    bus_stop(); wq();
    chk(!access, "R8", access, 0);
  endtask

  task automatic read_regs(input logic [3:0] p, input int n, input string req);
    int idx;
    bus_start();
    send_byte(8'hA2); chk(ack_seen, "R1", ack_seen, 1);
    send_byte({4'h0, p}); chk(ack_seen, "R2", ack_seen, 1);
    bus_rstart();
    chk(access, "R8", access, 1);
    send_byte(8'hA3); chk(ack_seen, "R7", ack_seen, 1);
    idx = p;
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1);
      chk(rd_byte == exp_mem[idx], req, rd_byte, exp_mem[idx]);
      idx = (idx + 1) % 16;
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin dev_mem[i] = 8'h00; exp_mem[i] = 8'h00; end
    repeat (5) @(negedge clk);
    // R10 reset state
    chk(!sda_oe && !access && !we, "R10", {sda_oe, access, we}, 0);
    rst_n = 1'b1;
    wq(2);
    chk(!sda_oe && !access && !we, "R10", {sda_oe, access, we}, 0);

    write_regs(4'h3, '{8'hA5, 8'h5A, 8'hC3}, "R3");
    write_regs(4'h1, '{8'hFF, 8'hFF}, "R3");
    write_regs(4'hE, '{8'h11, 8'h22, 8'h33}, "R5");
    for (int i = 0; i < 16; i++)
      chk(dev_mem[i] == exp_mem[i], "R3", dev_mem[i], exp_mem[i]);
    chk(we_cnt == exp_we, "R3", we_cnt, exp_we);

    // R4 R7 read back with repeated start
    read_regs(4'h3, 3, "R4");
    // R6 extra clocks after controller NACK: line must stay released
    for (int k = 0; k < 4; k++) begin
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); chk(sda_bus == 1'b1, "R6", sda_bus, 1); wq(); scl_m = 1'b0; wq();
    end
    bus_stop(); wq();
    chk(!access, "R8", access, 0);

    read_regs(4'hF, 2, "R5");
    bus_stop(); wq();
    read_regs(4'h1, 2, "R3");
    bus_stop(); wq();

    // R1 foreign addresses
    bus_start();
    send_byte(8'hA4); chk(!ack_seen, "R1", ack_seen, 0);
    chk(!access, "R8", access, 0);
    send_byte(8'h05); chk(!ack_seen, "R1", ack_seen, 0);
    send_byte(8'h77); chk(!ack_seen, "R1", ack_seen, 0);
    bus_stop(); wq();
    bus_start();
    send_byte(8'h53); chk(!ack_seen, "R1", ack_seen, 0);
    recv_byte(1'b0); chk(rd_byte == 8'hFF, "R1", rd_byte, 8'hFF);
    bus_stop(); wq();
    chk(we_cnt == exp_we, "R1", we_cnt, exp_we);

    // R11 STOP in the middle of a data byte
    bus_start();
    send_byte(8'hA2); send_byte(8'h07);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    bus_stop(); wq();
    chk(we_cnt == exp_we, "R11", we_cnt, exp_we);
    chk(dev_mem[7] == exp_mem[7], "R11", dev_mem[7], exp_mem[7]);
    chk(!access, "R8", access, 0);
    read_regs(4'h7, 1, "R11");
    bus_stop(); wq();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: act=hung exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule